// File: doc/BRIEF.md
# Two-Channel Audio Decimating Mixer

This block takes two one-bit tone waveforms that change at the generator's native rate and turns them into a stream of 8-bit PCM samples at a lower, fractional output rate. A phase accumulator is advanced by the output-rate constant on every native step. Whenever it holds at least the native-rate constant, one output event is pending. Because of this, a native step can give zero, one or several output events. The generator logic that produces the waveform bits sits outside this block.

Each channel has a 4-bit volume, and a shared master percentage scales both volumes. A channel adds its scaled amplitude when its waveform bit is high. In mono mode an event is one sample: the sum of both channels plus a DC offset. In stereo mode an event is two beats: first channel 0 plus the offset, then channel 1 plus the offset. Output uses a valid/ready handshake. While the consumer is not ready, no pending event is lost.

Top module: `pcm_rate_mixer`

## Requirements
- R1: A channel's amplitude equals floor(volume × 4 × percent / 100), for any percent from 0 to 127. A change of volume or percent reaches `out_data` after exactly one clock edge.
- R2: A channel whose waveform bit is 0 contributes 0. A channel whose bit is 1 contributes its amplitude. The waveform bits act on `out_data` combinationally.
- R3: Each cycle with `step_en` high adds OUTPUT_RATE to the accumulator. `out_valid` is high whenever the accumulator is at least NATIVE_RATE. With `out_ready` held high and no mode change, K steps from reset yield floor(K × OUTPUT_RATE / NATIVE_RATE) events.
- R4: When OUTPUT_RATE exceeds NATIVE_RATE, a single step can yield two or more events. They are presented one per clock. Each completed event subtracts NATIVE_RATE.
- R5: When `stereo_mode` = 0, each event is one beat. On that beat `out_chan` = 0 and `out_data` = saturate(contribution 0 + contribution 1 + `dc_offset`).
- R6: When `stereo_mode` = 1, each event is two beats. The first beat has `out_chan` = 0 and data = saturate(contribution 0 + offset). The second beat has `out_chan` = 1 and data = saturate(contribution 1 + offset). Only the second accepted beat completes the event.
- R7: While `out_ready` is low, `out_valid` stays high once raised and the accumulator is not decremented. Steps still accumulate, so all pending events are delivered after ready returns.
- R8: A sample never wraps. Any sum above 255 is output as 255.
- R9: After a synchronous active-low reset the accumulator is zero, `out_valid` is 0 and the stereo beat phase points at channel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | One native-rate step this cycle |
| wave0 | input | 1 | Channel 0 waveform bit |
| wave1 | input | 1 | Channel 1 waveform bit |
| vol0 | input | 4 | Channel 0 volume |
| vol1 | input | 4 | Channel 1 volume |
| master_pct | input | 7 | Master volume in percent |
| stereo_mode | input | 1 | 0: mono sum, 1: two-beat stereo |
| dc_offset | input | 8 | Offset added to every sample |
| out_ready | input | 1 | Consumer accepts a beat |
| out_valid | output | 1 | A beat is presented |
| out_data | output | 8 | Sample value |
| out_chan | output | 1 | 1 on the second (channel 1) stereo beat |

## Verification
The in-line assertions check on every cycle that `out_valid` holds through a stall, that it only falls after an accepted beat, and that a first stereo beat is always followed by a valid channel-1 beat. They also check that the accumulator keeps its headroom, that an amplitude never exceeds its bound and only moves after its inputs move, and that a sample is never below the offset. Only the bench scenarios can show the exact event count per step, the arithmetic of the percentage scaling, the saturation value, the one-cycle latency of a volume change and the loss-free delivery after a stall, because each of these needs known stimulus and an independently computed answer.

// File: rtl/pcm_mix_pkg.sv
// Package: shared helpers for the two-channel decimating mixer.
// Assumes the volume-times-percent product stays below 43690, where the
// reciprocal multiply below is exact against integer division by 100.
package pcm_mix_pkg;

    localparam int unsigned DIV100_RECIP = 5243;
    localparam int unsigned DIV100_SHIFT = 19;

    // floor(x / 100) by reciprocal multiply and shift
    function automatic int unsigned div_by_100(input int unsigned x);
        longint unsigned wide;
        wide = longint'(x) * longint'(DIV100_RECIP);
        return int'(wide >> DIV100_SHIFT);
    endfunction

endpackage

// File: rtl/mix_amp_scale.sv
// Module: mix_amp_scale
// Registers one channel's amplitude: floor(vol * 4 * pct / 100).
// Assumes the product fits the package divider's exact range.
module mix_amp_scale #(
    parameter int VOL_W   = 4,
    parameter int PCT_W   = 7,
    parameter int AMP_W   = 7,
    parameter int AMP_MAX = 76
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VOL_W-1:0] vol_i,
    input  logic [PCT_W-1:0] pct_i,
    output logic [AMP_W-1:0] amp_q
);
    import pcm_mix_pkg::*;

    logic [AMP_W-1:0] amp_d;

    // Scale volume by the master percentage
    always_comb begin
        amp_d = AMP_W'(div_by_100(int'({vol_i, 2'b00}) * int'(pct_i)));
    end

    // Hold the scaled amplitude for the sample path
    always_ff @(posedge clk) begin
        if (!rst_n) amp_q <= '0;
        else        amp_q <= amp_d;
    end

    assert_amp_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        amp_q <= AMP_W'(AMP_MAX));

    assert_amp_follows_inputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(vol_i) && $stable(pct_i)) |=> $stable(amp_q));
endmodule

// File: rtl/mix_phase_acc.sv
// Module: mix_phase_acc
// Fractional decimator: adds OUTPUT_RATE per native step, offers an event
// while the total is at least NATIVE_RATE, and in stereo splits each event
// into two beats. Assumes the consumer drains events before the
// accumulator nears its width limit.
module mix_phase_acc #(
    parameter int ACC_W       = 20,
    parameter int NATIVE_RATE = 31400,
    parameter int OUTPUT_RATE = 22050
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_en,
    input  logic stereo_i,
    input  logic ready_i,
    output logic valid_o,
    output logic second_o
);
    localparam logic [ACC_W-1:0] NAT_K     = ACC_W'(NATIVE_RATE);
    localparam logic [ACC_W-1:0] INC_K     = ACC_W'(OUTPUT_RATE);
    localparam logic [ACC_W-1:0] ACC_LIMIT = {ACC_W{1'b1}} - INC_K;

    logic [ACC_W-1:0] acc_q, acc_d;
    logic             half_q;
    logic             fire, done;

    // Handshake and event completion
    always_comb begin
        valid_o  = (acc_q >= NAT_K);
        fire     = valid_o && ready_i;
        done     = fire && (!stereo_i || half_q);
        second_o = stereo_i && half_q;
    end

    // Next accumulator value: add per step, subtract per completed event
    always_comb begin
        acc_d = acc_q;
        if (step_en) acc_d = acc_d + INC_K;
        if (done)    acc_d = acc_d - NAT_K;
    end

    // Accumulator register
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // Stereo beat phase: toggles on each accepted beat, idle in mono
    always_ff @(posedge clk) begin
        if (!rst_n)         half_q <= 1'b0;
        else if (!stereo_i) half_q <= 1'b0;
        else if (fire)      half_q <= !half_q;
    end

    assert_stall_holds_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> valid_o);

    assert_valid_drops_after_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid_o) |-> $past(fire));

    assert_second_beat_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && stereo_i && !half_q) |=> (valid_o && (second_o || !stereo_i)));

    assert_no_rise_without_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !valid_o) |=> !valid_o);

    assert_acc_headroom_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= ACC_LIMIT);
endmodule

// File: rtl/mix_sample_build.sv
// Module: mix_sample_build
// Forms the output sample from the gated channel amplitudes and the offset,
// in mono sum or per-channel stereo form, saturating at the sample maximum.
module mix_sample_build #(
    parameter int AMP_W = 7,
    parameter int SMP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AMP_W-1:0] amp0_i,
    input  logic [AMP_W-1:0] amp1_i,
    input  logic             wave0_i,
    input  logic             wave1_i,
    input  logic             stereo_i,
    input  logic             second_i,
    input  logic [SMP_W-1:0] offset_i,
    output logic [SMP_W-1:0] data_o
);
    localparam int SUM_W = ((AMP_W > SMP_W) ? AMP_W : SMP_W) + 2;
    localparam logic [SUM_W-1:0] SAT_K = SUM_W'({SMP_W{1'b1}});

    logic [SUM_W-1:0] part0, part1, sum;

    // Gate each amplitude by its waveform bit and select the mix
    always_comb begin
        part0 = wave0_i ? SUM_W'(amp0_i) : '0;
        part1 = wave1_i ? SUM_W'(amp1_i) : '0;
        if (!stereo_i)     sum = part0 + part1 + SUM_W'(offset_i);
        else if (second_i) sum = part1 + SUM_W'(offset_i);
        else               sum = part0 + SUM_W'(offset_i);
        data_o = (sum > SAT_K) ? {SMP_W{1'b1}} : sum[SMP_W-1:0];
    end

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        data_o >= offset_i);

    assert_silent_is_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wave0_i && !wave1_i) |-> (data_o == offset_i));
endmodule

// File: rtl/pcm_rate_mixer.sv
// Module: pcm_rate_mixer (top)
// Two one-bit channels at native rate in, 8-bit PCM beats at the output
// rate out. Rates are constants; the bench may shrink them.
module pcm_rate_mixer #(
    parameter int VOL_W       = 4,
    parameter int PCT_W       = 7,
    parameter int SMP_W       = 8,
    parameter int ACC_W       = 20,
    parameter int NATIVE_RATE = 31400,
    parameter int OUTPUT_RATE = 22050
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             wave0,
    input  logic             wave1,
    input  logic [VOL_W-1:0] vol0,
    input  logic [VOL_W-1:0] vol1,
    input  logic [PCT_W-1:0] master_pct,
    input  logic             stereo_mode,
    input  logic [SMP_W-1:0] dc_offset,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [SMP_W-1:0] out_data,
    output logic             out_chan
);
    localparam int NCH     = 2;
    localparam int AMP_MAX = ((2**VOL_W - 1) * 4 * (2**PCT_W - 1)) / 100;
    localparam int AMP_W   = $clog2(AMP_MAX + 1);

    logic [VOL_W-1:0] vol_arr [NCH];
    logic [AMP_W-1:0] amp_arr [NCH];
    logic             second;

    assign vol_arr[0] = vol0;
    assign vol_arr[1] = vol1;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        mix_amp_scale #(
            .VOL_W(VOL_W), .PCT_W(PCT_W), .AMP_W(AMP_W), .AMP_MAX(AMP_MAX)
        ) u_scale (
            .clk(clk), .rst_n(rst_n), .vol_i(vol_arr[ch]),
            .pct_i(master_pct), .amp_q(amp_arr[ch])
        );
    end

    mix_phase_acc #(
        .ACC_W(ACC_W), .NATIVE_RATE(NATIVE_RATE), .OUTPUT_RATE(OUTPUT_RATE)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .stereo_i(stereo_mode),
        .ready_i(out_ready), .valid_o(out_valid), .second_o(second)
    );

    mix_sample_build #(.AMP_W(AMP_W), .SMP_W(SMP_W)) u_build (
        .clk(clk), .rst_n(rst_n), .amp0_i(amp_arr[0]), .amp1_i(amp_arr[1]),
        .wave0_i(wave0), .wave1_i(wave1), .stereo_i(stereo_mode),
        .second_i(second), .offset_i(dc_offset), .data_o(out_data)
    );

    assign out_chan = second;
endmodule

// File: tb/pcm_rate_mixer_test.sv
`timescale 1ns/1ps
module pcm_rate_mixer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_en = 1'b0, wave0 = 1'b0, wave1 = 1'b0;
    logic [3:0] vol0 = '0, vol1 = '0;
    logic [6:0] master_pct = '0;
    logic       stereo_mode = 1'b0, out_ready = 1'b0;
    logic [7:0] dc_offset = '0;
    logic       out_valid, out_chan;
    logic [7:0] out_data;

    int checks = 0, errors = 0;
    int beats = 0, beats_ch1 = 0;

    always #2.5 clk = ~clk;

    pcm_rate_mixer #(.NATIVE_RATE(3), .OUTPUT_RATE(5), .ACC_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .wave0(wave0), .wave1(wave1),
        .vol0(vol0), .vol1(vol1), .master_pct(master_pct), .stereo_mode(stereo_mode),
        .dc_offset(dc_offset), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .out_chan(out_chan)
    );

    // Columns: vol0, vol1, pct, wave0, wave1, offset, expected mono sample
    localparam int NV = 8;
    localparam int VEC [NV][7] = '{
        '{15, 15, 100, 1, 1,   0, 120},
        '{15, 15, 100, 1, 1, 200, 255},
        '{ 7,  3,  50, 1, 0,  10,  24},
        '{ 9, 12,  33, 0, 1,   5,  20},
        '{ 0, 15, 100, 1, 1, 128, 188},
        '{15,  1,   0, 1, 1,   3,   3},
        '{13, 11,  77, 1, 1, 100, 173},
        '{15, 15, 127, 1, 1, 140, 255}
    };

    // Count accepted beats away from the clock edge
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            beats++;
            if (out_chan) beats_ch1++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step_en = 1'b0; out_ready = 1'b0; stereo_mode = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic step_once();
        step_en = 1'b1;
        tick(1);
        step_en = 1'b0;
    endtask

    function automatic int amp(input int v, input int p);
        return (v * 4 * p) / 100;
    endfunction

    function automatic int sat(input int x);
        return (x > 255) ? 255 : x;
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int b0, b1;
        int per_step [6] = '{1, 2, 2, 1, 2, 2};
        do_reset();
        @(negedge clk);
        check("R9", "valid after reset", int'(out_valid), 0);
        check("R9", "chan after reset", int'(out_chan), 0);

        // Table walk: mono value, then both stereo beats (R1 R2 R5 R6 R8)
        for (int i = 0; i < NV; i++) begin
            int a0, a1, e_l, e_r;
            tick(1);
            vol0 = 4'(VEC[i][0]); vol1 = 4'(VEC[i][1]); master_pct = 7'(VEC[i][2]);
            wave0 = VEC[i][3][0]; wave1 = VEC[i][4][0]; dc_offset = 8'(VEC[i][5]);
            stereo_mode = 1'b0; out_ready = 1'b0;
            a0 = VEC[i][3] ? amp(VEC[i][0], VEC[i][2]) : 0;
            a1 = VEC[i][4] ? amp(VEC[i][1], VEC[i][2]) : 0;
            e_l = sat(a0 + VEC[i][5]);
            e_r = sat(a1 + VEC[i][5]);
            step_once();
            @(negedge clk);
            check("R5", $sformatf("vec%0d mono valid", i), int'(out_valid), 1);
            check("R5_R8", $sformatf("vec%0d mono data", i), int'(out_data), VEC[i][6]);
            tick(1);
            stereo_mode = 1'b1;
            @(negedge clk);
            check("R6", $sformatf("vec%0d left chan", i), int'(out_chan), 0);
            check("R6_R1", $sformatf("vec%0d left data", i), int'(out_data), e_l);
            tick(1);
            out_ready = 1'b1;
            tick(1);
            out_ready = 1'b0;
            @(negedge clk);
            check("R6", $sformatf("vec%0d right chan", i), int'(out_chan), 1);
            check("R6_R2", $sformatf("vec%0d right data", i), int'(out_data), e_r);
            tick(1);
            out_ready = 1'b1;
            tick(1);
            out_ready = 1'b0;
            stereo_mode = 1'b0;
        end

        // Reset clears leftover accumulator (R9)
        do_reset();
        @(negedge clk);
        check("R9", "valid after mid-run reset", int'(out_valid), 0);

        // Decimation ratio, several events per step (R3 R4)
        tick(1);
        out_ready = 1'b1;
        for (int k = 0; k < 6; k++) begin
            b0 = beats;
            step_once();
            tick(5);
            check("R3_R4", $sformatf("beats for step %0d", k + 1), beats - b0, per_step[k]);
        end
        @(negedge clk);
        check("R3", "valid idle after ratio run", int'(out_valid), 0);

        // Stall: nothing lost, accumulation continues (R7)
        do_reset();
        out_ready = 1'b0;
        b0 = beats;
        step_once(); step_once(); step_once();
        tick(10);
        @(negedge clk);
        check("R7", "valid held in stall", int'(out_valid), 1);
        check("R7", "no beats during stall", beats - b0, 0);
        tick(1);
        out_ready = 1'b1;
        tick(10);
        check("R7", "beats after stall", beats - b0, 5);
        @(negedge clk);
        check("R7", "valid after drain", int'(out_valid), 0);

        // Stereo event count and interleave (R6)
        do_reset();
        stereo_mode = 1'b1;
        out_ready = 1'b1;
        b0 = beats; b1 = beats_ch1;
        step_once(); step_once();
        tick(10);
        check("R6", "stereo beats", beats - b0, 6);
        check("R6", "stereo channel-1 beats", beats_ch1 - b1, 3);
        out_ready = 1'b0;
        stereo_mode = 1'b0;

        // Volume change latency of one edge (R1)
        do_reset();
        vol0 = 4'd0; vol1 = 4'd0; master_pct = 7'd100;
        wave0 = 1'b1; wave1 = 1'b0; dc_offset = 8'd7;
        step_once();
        @(negedge clk);
        check("R1", "data before volume change", int'(out_data), 7);
        tick(1);
        vol0 = 4'd15;
        @(negedge clk);
        check("R1", "data before edge", int'(out_data), 7);
        tick(1);
        @(negedge clk);
        check("R1", "data after edge", int'(out_data), 67);
        wave0 = 1'b0;
        #1;
        check("R2", "wave low gives offset", int'(out_data), 7);

        tick(2);
        finish_run();
    end
endmodule